// File: doc/BRIEF.md
# Grouped-Table Bit-Serial FIR Filter

This block computes a fixed-coefficient FIR filter without multipliers. The taps are split into groups of four consecutive taps. Each group has its own small table of precomputed coefficient sums. The table is addressed by one bit taken from each of the group's four stored samples. Storage therefore grows in step with the tap count. A single table indexed by every tap would double in size with each added tap.

Each output takes one cycle per input bit, least significant bit first. In each cycle the group table outputs are summed and passed to one shared accumulator. The accumulator weights the sum by the bit position. It adds on every ordinary bit and subtracts on the two's-complement sign bit. When the tap count is not a multiple of four, the last group has a smaller table sized to the leftover taps.

A new sample is offered with a valid/ready handshake, and the result comes out with a one-cycle valid pulse. The tap count, the sample and coefficient widths, and the coefficient values are all fixed when the design is built.

Top module: `da_group_fir`

## Requirements
- R1: After a synchronous active-low reset, in_ready is 1, out_valid is 0, out_data is 0 and every stored sample is zero.
- R2: A sample is accepted on a clock edge where in_valid and in_ready are both 1. From the cycle after that edge, in_ready stays 0 until the result is produced. Samples offered while in_ready is 0 are ignored and do not enter the delay line.
- R3: out_valid is a one-cycle pulse. It rises exactly DW (default 8) clock edges after the edge that accepted the sample.
- R4: out_data equals the sum over k = 0..TAPS-1 of c[k]·x[n-k]. Here x[n] is the newest accepted sample, samples older than the first accepted one count as zero, and c[k] is the signed field COEFS[k*CW +: CW]. out_data is read as two's complement.
- R5: Samples are two's complement, and their top bit carries weight -2^(DW-1). The most negative sample value gives the exact result.
- R6: When TAPS is not a multiple of 4, the last TAPS mod 4 taps are served by a smaller table. They contribute their coefficients exactly like the other taps. With TAPS = 10, these are taps 8 and 9.
- R7: No intermediate sum overflows. Runs of all-maximum and all-minimum samples give exact results.
- R8: in_ready returns to 1 in the same cycle that out_valid is 1. A sample offered then is accepted, so samples can stream with one result every DW+1 cycles.
- R9: out_data holds its value in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_data | input | DW | Sample, two's complement |
| in_ready | output | 1 | The block can take a sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OW | Filter output, two's complement |

## Verification
The assertions assume that DW is at least 2, so two result pulses can never fall in adjacent cycles. They also assume that reset is held for at least two edges before the first check. Samples are driven on the falling edge. A sample is offered only after in_ready has been seen high at that edge, and ignored samples are driven only during windows where in_ready is known to be low. A reference model convolves the accepted samples with the coefficient list. The monitor compares both the value and the cycle of every result pulse.

// File: rtl/da_fir_pkg.sv
// Shared sizing helpers for the grouped-table filter.
// Assumes: group size is fixed at four taps.
package da_fir_pkg;
    localparam int GROUP_TAPS = 4;

    // Number of groups needed to cover a given tap count.
    function automatic int group_count(input int taps);
        return (taps + GROUP_TAPS - 1) / GROUP_TAPS;
    endfunction

    // Taps served by group g (four, or the remainder for the last group).
    function automatic int group_size(input int taps, input int g);
        return ((taps - GROUP_TAPS * g) >= GROUP_TAPS) ? GROUP_TAPS
                                                        : (taps - GROUP_TAPS * g);
    endfunction
endpackage

// File: rtl/da_tap_line.sv
// Sample delay line. Stores the last TAPS accepted samples.
// It presents one bit-plane of them, selected by bit_sel.
// Assumes: load is a single-cycle strobe; bit_sel < DW.
module da_tap_line #(
    parameter int TAPS = 10,
    parameter int DW   = 8,
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    din,
    input  logic [BCW-1:0]   bit_sel,
    output logic [TAPS-1:0]  plane
);
    logic [DW-1:0] taps_q [TAPS];

    // Shift a new sample in at tap 0 and move older samples down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
        end else if (load) begin
            taps_q[0] <= din;
            for (int k = 1; k < TAPS; k++) taps_q[k] <= taps_q[k-1];
        end
    end

    // Pick out the selected bit of every stored sample.
    always_comb begin
        for (int k = 0; k < TAPS; k++) plane[k] = taps_q[k][bit_sel];
    end
endmodule

// File: rtl/da_group_rom.sv
// Coefficient-sum table for one group of N taps.
// Entry a is the sum of the coefficients whose address bit is set in a.
// Assumes: N is 1..4; GCOEF holds N signed CW-bit values, tap j at [j*CW +: CW].
module da_group_rom #(
    parameter int N  = 4,
    parameter int CW = 8,
    parameter int TW = CW + 2,
    parameter logic [N*CW-1:0] GCOEF = '0
) (
    input  logic [N-1:0]          addr,
    output logic signed [TW-1:0]  val
);
    localparam int ENTRIES = 1 << N;

    // Build every table entry once, while the design is elaborated.
    function automatic logic [ENTRIES*TW-1:0] build_table();
        logic [ENTRIES*TW-1:0] tbl;
        logic signed [TW-1:0]  e;
        tbl = '0;
        for (int a = 0; a < ENTRIES; a++) begin
            e = '0;
            for (int j = 0; j < N; j++) begin
                if (a[j])
                    e = e + {{(TW-CW){GCOEF[j*CW+CW-1]}}, GCOEF[j*CW +: CW]};
            end
            tbl[a*TW +: TW] = e;
        end
        return tbl;
    endfunction

    localparam logic [ENTRIES*TW-1:0] TABLE = build_table();

    // Table read.
    assign val = TABLE[int'(addr)*TW +: TW];
endmodule

// File: rtl/da_accum.sv
// Shift-weighted add/subtract accumulator for the bit-serial filter.
// Adds psum scaled by 2^shamt on ordinary bit-planes and subtracts on the sign plane.
// Assumes: step is high on consecutive cycles; first marks bit 0; last marks bit DW-1.
module da_accum #(
    parameter int SW   = 12,
    parameter int DW   = 8,
    parameter int ACCW = SW + DW,
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic                   first,
    input  logic                   last,
    input  logic [BCW-1:0]         shamt,
    input  logic signed [SW-1:0]   psum,
    output logic signed [ACCW-1:0] result,
    output logic                   done
);
    logic signed [ACCW-1:0] acc_q, term, base, acc_next;

    // Weight the plane sum and fold it into the running total.
    always_comb begin
        term     = {{(ACCW-SW){psum[SW-1]}}, psum} <<< shamt;
        base     = first ? '0 : acc_q;
        acc_next = last ? (base - term) : (base + term);
    end

    // Hold the running total, the finished result and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= step && last;
            if (step) acc_q <= acc_next;
            if (step && last) result <= acc_next;
        end
    end

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

// File: rtl/da_group_fir.sv
// Grouped-table bit-serial FIR filter (top).
// TAPS taps are split into groups of four, each with its own coefficient-sum table.
// Group outputs are summed per bit-plane and passed to one sign-aware accumulator.
// Assumes: DW >= 2; COEFS holds tap k at [k*CW +: CW], signed.
module da_group_fir
    import da_fir_pkg::*;
#(
    parameter int TAPS = 10,
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter logic [TAPS*CW-1:0] COEFS = {8'hFB, 8'd19, 8'h80, 8'd127, 8'd64,
                                           8'hD8, 8'd25, 8'd12, 8'hF9, 8'd3},
    localparam int NGRP = (TAPS + 3) / 4,
    localparam int TW   = CW + 2,
    localparam int SW   = TW + $clog2(NGRP),
    localparam int OW   = SW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    logic                  busy;
    logic [BCW-1:0]        bit_q;
    logic                  accept;
    logic [TAPS-1:0]       plane;
    logic signed [SW-1:0]  gval [NGRP];
    logic signed [SW-1:0]  plane_sum;
    logic signed [OW-1:0]  result;

    assign accept   = in_valid && !busy;
    assign in_ready = !busy;

    // Sequence DW bit-planes after each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            bit_q <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            bit_q <= '0;
        end else if (busy) begin
            if (bit_q == LAST_BIT) busy <= 1'b0;
            bit_q <= bit_q + 1'b1;
        end
    end

    da_tap_line #(.TAPS(TAPS), .DW(DW)) u_line (
        .clk(clk), .rst_n(rst_n), .load(accept), .din(in_data),
        .bit_sel(bit_q), .plane(plane)
    );

    // One table per group; the last group is sized to the leftover taps.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int NG = group_size(TAPS, g);
        localparam logic [NG*CW-1:0] GC = COEFS[4*g*CW +: NG*CW];
        logic signed [TW-1:0] tval;

        da_group_rom #(.N(NG), .CW(CW), .TW(TW), .GCOEF(GC)) u_rom (
            .addr(plane[4*g +: NG]), .val(tval)
        );
        assign gval[g] = {{(SW-TW){tval[TW-1]}}, tval};
    end

    // Adder tree over the group outputs, widened so it cannot overflow.
    always_comb begin
        plane_sum = '0;
        for (int g = 0; g < NGRP; g++) plane_sum = plane_sum + gval[g];
    end

    da_accum #(.SW(SW), .DW(DW), .ACCW(OW)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(busy),
        .first(bit_q == '0), .last(bit_q == LAST_BIT),
        .shamt(bit_q), .psum(plane_sum),
        .result(result), .done(out_valid)
    );

    assign out_data = result;

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);
    // R2
    busy_until_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_q != LAST_BIT) |=> !in_ready);
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R8
    ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
endmodule

// File: tb/tb_da_group_fir.sv
module tb_da_group_fir;
    localparam int TAPS = 10;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int OW   = 20;
    localparam logic [TAPS*CW-1:0] C = {8'hFB, 8'd19, 8'h80, 8'd127, 8'd64,
                                        8'hD8, 8'd25, 8'd12, 8'hF9, 8'd3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [OW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    longint hist [TAPS];
    longint q_val [$];
    int     q_cyc [$];
    string  q_tag [$];

    always #4 clk = ~clk;

    da_group_fir #(.TAPS(TAPS), .DW(DW), .CW(CW), .COEFS(C)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
    );

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: offer one sample, push the model's result and cycle into the scoreboard.
    task automatic send(input logic signed [DW-1:0] x, input string tag, input bit junk);
        longint y;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'(x);
        y = 0;
        for (int k = 0; k < TAPS; k++)
            y += longint'($signed(C[k*CW +: CW])) * hist[k];
        q_val.push_back(y);
        q_cyc.push_back(ncyc + 1 + DW);
        q_tag.push_back(tag);
        @(negedge clk);
        if (junk) begin
            for (int i = 0; i < DW - 1; i++) begin
                in_data = 8'sd99;                  // R2: offered while busy
                check("R2 ready low while busy", longint'(in_ready), 0);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    // Monitor: compare each result pulse with the next scoreboard entry.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_val.size() == 0) begin
                check("R3 unexpected result pulse", 1, 0);
            end else begin
                longint ev;
                int ec;
                string tg;
                ev = q_val.pop_front();
                ec = q_cyc.pop_front();
                tg = q_tag.pop_front();
                check({tg, " value"}, longint'($signed(out_data)), ev);
                check("R3 latency", longint'(ncyc), longint'(ec));
                check("R8 ready with result", longint'(in_ready), 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 in_ready", longint'(in_ready), 1);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_data", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", longint'(out_valid), 0);

        // R4/R6: unit impulse walks through every coefficient, incl. remainder taps
        send(8'sd1, "R6 impulse", 1'b0);
        for (int i = 0; i < TAPS; i++) send(8'sd0, "R6 impulse tail", 1'b0);

        // R5: most negative sample impulse
        send(8'h80, "R5 min impulse", 1'b0);
        for (int i = 0; i < TAPS; i++) send(8'sd0, "R5 tail", 1'b0);

        // R7: extreme runs
        for (int i = 0; i < TAPS + 2; i++) send(8'h80, "R7 all min", 1'b0);
        for (int i = 0; i < TAPS + 2; i++) send(8'h7F, "R7 all max", 1'b0);

        // R2: samples offered while busy must not enter the delay line
        for (int i = 0; i < 6; i++) send(8'(i * 17 - 40), "R2 ignored while busy", 1'b1);

        // R4/R8: pseudo-random stream, back to back
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[7:0], "R4 random", 1'b0);
        end

        // R9: out_data holds between pulses
        repeat (DW + 4) @(negedge clk);
        begin
            logic [OW-1:0] held;
            held = out_data;
            repeat (5) @(negedge clk);
            check("R9 hold", longint'(out_data), longint'(held));
        end
        check("R3 scoreboard drained", longint'(q_val.size()), 0);
        finish_run();
    end
endmodule